// File: doc/BRIEF.md
# Temperature-Indexed Table Fetch and DAC Code Selector

This block feeds two current-generator channels. Each channel picks a 6-bit row index, turns it into a byte address inside its own 64-row table, and reads that byte from a synchronous byte memory. The returned byte becomes the channel's 8-bit DAC code. The index normally comes from the converter result, which usually tracks temperature. A control field can replace it with a fixed row. The code can also bypass the table completely and come straight from a control byte.

The two channels share a single memory read port, and channel 1 wins whenever both channels want it. A channel refetches after reset, whenever its selected row changes, and whenever a memory write lands on the byte it currently selects. The DAC code keeps its old value until a fetch completes, then takes the new value in a single cycle. Direction and full-scale range bits from the control bytes pass straight through to the analog side.

Top module: `lut_dac_sel`

## Requirements
- R1: The channel 1 row address is 0x090 plus the 6-bit row index. The channel 2 row address is 0x0D0 plus the row index. Both are 9-bit byte addresses driven on `mem_rd_addr` while `mem_rd_en` is high.
- R2: When `ctrl5[4]` is 1, channel 1 uses `ctrl1[5:0]` as its row index. When `ctrl5[6]` is 1, channel 2 uses `ctrl2[5:0]`. In either case `adc_code` has no effect on that channel, and bits [7:6] of the field are ignored. When the select bit is 0, the index is `adc_code`.
- R3: When `ctrl5[5]` is 1, `dac1_code` equals `ctrl3`, one clock after it is presented. When `ctrl5[7]` is 1, `dac2_code` equals `ctrl4` in the same way. When a select bit is 0, the matching control byte has no effect and the code is the channel's last fetched table byte.
- R4: A channel requests a fetch after reset, when its row index differs from the previous cycle's index, or when `wr_en` writes the address the channel currently selects. A request stays pending until granted. At most one read is issued per cycle, and channel 1 is granted first.
- R5: Read data arrives one cycle after the request. The DAC code takes that byte on the next clock edge and otherwise holds its value.
- R6: While `rst_n` is low, and after it is released until the first fetch returns, both DAC codes are 0.
- R7: `dir1` follows `ctrl0[5]` and `dir2` follows `ctrl0[6]`. A value of 0 means the channel sources current and 1 means it sinks current.
- R8: `fs1` follows `ctrl5[1:0]` and `fs2` follows `ctrl5[3:2]`. Code 00 means an external resistor sets full scale. Codes 01, 10 and 11 select the small, medium and large fixed ranges.
- R9: A write to the selected row in the same cycle as that row's read issues still leaves the DAC code at the newly written byte once the refetch completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_code | input | 6 | Converter result used as the default row index |
| ctrl0 | input | 8 | Control byte carrying the direction bits |
| ctrl1 | input | 8 | Direct row index for channel 1 (bits 5:0) |
| ctrl2 | input | 8 | Direct row index for channel 2 (bits 5:0) |
| ctrl3 | input | 8 | Direct DAC byte for channel 1 |
| ctrl4 | input | 8 | Direct DAC byte for channel 2 |
| ctrl5 | input | 8 | Select bits and full-scale fields |
| wr_en | input | 1 | Memory write strobe, observed only |
| wr_addr | input | 9 | Memory write address, observed only |
| mem_rd_en | output | 1 | Read request to the byte memory |
| mem_rd_addr | output | 9 | Read byte address |
| mem_rd_data | input | 8 | Read data, valid one cycle after the request |
| dac1_code | output | 8 | Channel 1 DAC code |
| dac2_code | output | 8 | Channel 2 DAC code |
| dir1 | output | 1 | Channel 1 direction, 1 means sink |
| dir2 | output | 1 | Channel 2 direction, 1 means sink |
| fs1 | output | 2 | Channel 1 full-scale range code |
| fs2 | output | 2 | Channel 2 full-scale range code |

## Verification
Two events can coincide in one cycle: a table read for a row is issued, and a memory write lands on that same row. The memory returns the old byte, so a correct design must refetch. The bench provokes this by moving the converter result one cycle and writing the new row's byte the next cycle, exactly when the read goes out. It then checks that the code settles on the written byte. The second collision is between the two channels both having pending fetches. The bench creates it on every converter change, and its reference model predicts the read address each cycle, which confirms that channel 1 goes first and channel 2 follows.

// File: rtl/lut_dac_sel.sv
module lut_dac_sel #(
  parameter int AW = 9,
  parameter int DW = 8,
  parameter int RW = 6,
  parameter logic [AW-1:0] BASE1 = 9'h090,
  parameter logic [AW-1:0] BASE2 = 9'h0D0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] adc_code,
  input  logic [DW-1:0] ctrl0,
  input  logic [DW-1:0] ctrl1,
  input  logic [DW-1:0] ctrl2,
  input  logic [DW-1:0] ctrl3,
  input  logic [DW-1:0] ctrl4,
  input  logic [DW-1:0] ctrl5,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [DW-1:0] mem_rd_data,
  output logic [DW-1:0] dac1_code,
  output logic [DW-1:0] dac2_code,
  output logic          dir1,
  output logic          dir2,
  output logic [1:0]    fs1,
  output logic [1:0]    fs2
);

  logic [1:0][RW-1:0] row, row_q;
  logic [1:0][AW-1:0] addr;
  logic [1:0][DW-1:0] tbl, dac, dctl;
  logic [1:0]         pend, drow, ddac, hit, chg, ret;
  logic               gsel, infl, infl_ch;

  assign drow   = {ctrl5[6], ctrl5[4]};
  assign ddac   = {ctrl5[7], ctrl5[5]};
  assign dctl   = {ctrl4, ctrl3};
  assign row[0] = drow[0] ? ctrl1[RW-1:0] : adc_code;
  assign row[1] = drow[1] ? ctrl2[RW-1:0] : adc_code;
  assign addr[0] = BASE1 + AW'(row[0]);
  assign addr[1] = BASE2 + AW'(row[1]);

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      hit[i] = wr_en && (wr_addr == addr[i]);
      chg[i] = row[i] != row_q[i];
      ret[i] = infl && (infl_ch == 1'(i));
    end
  end

  assign gsel        = ~pend[0];
  assign mem_rd_en   = |pend;
  assign mem_rd_addr = addr[gsel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= 2'b11;
      row_q   <= '0;
      infl    <= 1'b0;
      infl_ch <= 1'b0;
      tbl     <= '0;
      dac     <= '0;
    end else begin
      infl    <= mem_rd_en;
      infl_ch <= gsel;
      for (int i = 0; i < 2; i++) begin
        row_q[i] <= row[i];
        pend[i]  <= (pend[i] && !(mem_rd_en && gsel == 1'(i))) || chg[i] || hit[i];
        if (ret[i]) tbl[i] <= mem_rd_data;
        dac[i] <= ddac[i] ? dctl[i] : (ret[i] ? mem_rd_data : tbl[i]);
      end
    end
  end

  assign dac1_code = dac[0];
  assign dac2_code = dac[1];
  assign dir1 = ctrl0[5];
  assign dir2 = ctrl0[6];
  assign fs1  = ctrl5[1:0];
  assign fs2  = ctrl5[3:2];

endmodule

// File: rtl/lut_dac_sel_chk.sv
module lut_dac_sel_chk #(
  parameter int AW = 9,
  parameter int DW = 8,
  parameter int RW = 6,
  parameter logic [AW-1:0] BASE1 = 9'h090,
  parameter logic [AW-1:0] BASE2 = 9'h0D0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_rd_en,
  input logic [AW-1:0] mem_rd_addr,
  input logic [DW-1:0] mem_rd_data,
  input logic [1:0]    pend,
  input logic          infl,
  input logic          infl_ch,
  input logic [DW-1:0] ctrl3,
  input logic [DW-1:0] ctrl5,
  input logic [DW-1:0] tbl0,
  input logic [DW-1:0] dac1_code
);
  localparam int ROWS = 1 << RW;

  p_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> ((int'(mem_rd_addr) >= int'(BASE1) && int'(mem_rd_addr) < int'(BASE1) + ROWS) ||
                   (int'(mem_rd_addr) >= int'(BASE2) && int'(mem_rd_addr) < int'(BASE2) + ROWS)));

  p_ch1_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pend[0] |-> (mem_rd_en && int'(mem_rd_addr) >= int'(BASE1) && int'(mem_rd_addr) < int'(BASE1) + ROWS));

  p_direct_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl5[5] |=> dac1_code == $past(ctrl3));

  p_track_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl5[5] |=> dac1_code == tbl0);

  p_return_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (infl && !infl_ch && !ctrl5[5]) |=> dac1_code == $past(mem_rd_data));
endmodule

bind lut_dac_sel lut_dac_sel_chk #(.AW(AW), .DW(DW), .RW(RW), .BASE1(BASE1), .BASE2(BASE2)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
  .mem_rd_data(mem_rd_data), .pend(pend), .infl(infl), .infl_ch(infl_ch),
  .ctrl3(ctrl3), .ctrl5(ctrl5), .tbl0(tbl[0]), .dac1_code(dac1_code)
);

// File: tb/lut_dac_sel_tb.sv
module lut_dac_sel_tb;
  localparam int CLK_NS = 10;

  logic clk = 0, rst_n = 0;
  logic [5:0] adc = 0;
  logic [7:0] c0 = 0, c1 = 0, c2 = 0, c3 = 0, c4 = 0, c5 = 0;
  logic wr_en = 0;
  logic [8:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic rd_en;
  logic [8:0] rd_addr;
  logic [7:0] rd_data = 0;
  logic [7:0] d1, d2;
  logic dr1, dr2;
  logic [1:0] f1, f2;
  logic [7:0] mem [512];

  int n_chk = 0, n_bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  lut_dac_sel u_dut (
    .clk(clk), .rst_n(rst_n), .adc_code(adc),
    .ctrl0(c0), .ctrl1(c1), .ctrl2(c2), .ctrl3(c3), .ctrl4(c4), .ctrl5(c5),
    .wr_en(wr_en), .wr_addr(wr_addr),
    .mem_rd_en(rd_en), .mem_rd_addr(rd_addr), .mem_rd_data(rd_data),
    .dac1_code(d1), .dac2_code(d2), .dir1(dr1), .dir2(dr2), .fs1(f1), .fs2(f2)
  );

  initial for (int i = 0; i < 512; i++) mem[i] = 8'(i * 37 + 11) ^ 8'(i >> 3);

  always @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_pend[2], m_rowq[2], m_tbl[2], m_dac[2], m_row[2], m_addr[2];
  int m_infl, m_inflch, m_data, m_rden, m_gch;

  function automatic void m_eval();
    m_row[0] = c5[4] ? int'(c1 & 8'h3F) : int'(adc);
    m_row[1] = c5[6] ? int'(c2 & 8'h3F) : int'(adc);
    m_addr[0] = 'h90 + m_row[0];
    m_addr[1] = 'hD0 + m_row[1];
    m_rden = (m_pend[0] != 0 || m_pend[1] != 0) ? 1 : 0;
    m_gch = (m_pend[0] != 0) ? 0 : 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_pend[c] = 1; m_rowq[c] = 0; m_tbl[c] = 0; m_dac[c] = 0;
      end
      m_infl = 0; m_inflch = 0; m_data = 0;
    end else begin
      int hit[2], chg[2];
      m_eval();
      for (int c = 0; c < 2; c++) begin
        bit ret, dd;
        int ctl;
        hit[c] = (wr_en && int'(wr_addr) == m_addr[c]) ? 1 : 0;
        chg[c] = (m_row[c] != m_rowq[c]) ? 1 : 0;
        ret = m_infl != 0 && m_inflch == c;
        dd = (c == 0) ? c5[5] : c5[7];
        ctl = (c == 0) ? int'(c3) : int'(c4);
        m_dac[c] = dd ? ctl : (ret ? m_data : m_tbl[c]);
        if (ret) m_tbl[c] = m_data;
      end
      if (m_rden != 0) m_data = int'(mem[m_addr[m_gch]]);
      m_infl = m_rden;
      m_inflch = m_gch;
      for (int c = 0; c < 2; c++) begin
        m_pend[c] = ((m_pend[c] != 0 && !(m_rden != 0 && m_gch == c)) || chg[c] != 0 || hit[c] != 0) ? 1 : 0;
        m_rowq[c] = m_row[c];
      end
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      m_eval();
      chk("R5 dac1", int'(d1), m_dac[0]);
      chk("R5 dac2", int'(d2), m_dac[1]);
      chk("R4 rd_en", int'(rd_en), m_rden);
      if (m_rden != 0) chk("R1 rd_addr", int'(rd_addr), m_addr[m_gch]);
      chk("R7 dir", int'({dr2, dr1}), int'({c0[6], c0[5]}));
      chk("R8 fs", int'({f2, f1}), int'(c5[3:0]));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_NS * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    cyc(3);
    chk("R6 reset dac1", int'(d1), 0);
    chk("R6 reset dac2", int'(d2), 0);
    rst_n = 1;
    cyc(1);
    chk("R6 before fetch dac1", int'(d1), 0);
    chk("R6 before fetch dac2", int'(d2), 0);
    cyc(4);
    chk("R1 first dac1", int'(d1), int'(mem['h90]));
    chk("R1 first dac2", int'(d2), int'(mem['hD0]));

    for (int k = 1; k < 22; k++) begin
      adc = 6'(k * 3 + 1);
      cyc(5);
      chk("R1 sweep dac1", int'(d1), int'(mem['h90 + int'(adc)]));
      chk("R1 sweep dac2", int'(d2), int'(mem['hD0 + int'(adc)]));
    end
    for (int k = 0; k < 20; k++) begin
      adc = 6'(k * 11 + 5);
      cyc(1);
    end
    cyc(5);
    chk("R4 after burst dac2", int'(d2), int'(mem['hD0 + int'(adc)]));

    c1 = 8'hEA;
    c5[4] = 1;
    cyc(5);
    chk("R2 direct row dac1", int'(d1), int'(mem['h90 + 'h2A]));
    for (int k = 0; k < 4; k++) begin
      adc = 6'(k * 17 + 2);
      cyc(5);
      chk("R2 adc ignored dac1", int'(d1), int'(mem['h90 + 'h2A]));
      chk("R2 ch2 follows adc", int'(d2), int'(mem['hD0 + int'(adc)]));
    end
    c2 = 8'h07;
    c5[6] = 1;
    cyc(5);
    chk("R2 direct row dac2", int'(d2), int'(mem['hD0 + 7]));
    c5[4] = 0; c5[6] = 0;

    c4 = 8'h5C;
    c5[7] = 1;
    cyc(2);
    chk("R3 direct dac2", int'(d2), 'h5C);
    c3 = 8'hA5;
    adc = 6'd33;
    cyc(5);
    chk("R3 table held dac2", int'(d2), 'h5C);
    chk("R3 ctrl3 ignored dac1", int'(d1), int'(mem['h90 + 33]));
    c5[7] = 0;
    cyc(5);
    chk("R3 back to table dac2", int'(d2), int'(mem['hD0 + 33]));

    adc = 6'd10;
    cyc(5);
    adc = 6'd12;
    cyc(1);
    wr_en = 1; wr_addr = 9'h09C; wr_data = 8'h77;
    cyc(1);
    wr_en = 0;
    cyc(6);
    chk("R9 write during fetch dac1", int'(d1), 'h77);
    wr_en = 1; wr_addr = 9'h0DC; wr_data = 8'h3E;
    cyc(1);
    wr_en = 0;
    cyc(6);
    chk("R9 write hit dac2", int'(d2), 'h3E);
    wr_en = 1; wr_addr = 9'h095; wr_data = 8'h01;
    cyc(1);
    wr_en = 0;
    cyc(4);
    chk("R4 unrelated write dac1", int'(d1), 'h77);

    c0 = 8'h20; c5[3:0] = 4'b1001;
    cyc(1);
    chk("R7 dir1 sink", int'(dr1), 1);
    chk("R7 dir2 source", int'(dr2), 0);
    chk("R8 fs1", int'(f1), 1);
    chk("R8 fs2", int'(f2), 2);
    c0 = 8'h40; c5[3:0] = 4'b0111;
    cyc(1);
    chk("R7 dir2 sink", int'({dr2, dr1}), 2);
    chk("R8 fs pair", int'({f2, f1}), 'h7);

    rst_n = 0;
    cyc(1);
    chk("R6 re-reset dac1", int'(d1), 0);
    rst_n = 1;
    cyc(6);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule